// File: doc/BRIEF.md
# Parity-Steered Mesh Route Encoder

This block makes the routing decision at one router of a two-dimensional mesh network-on-chip. It accepts a packet header that carries a data word and the source and destination coordinates, along with the coordinates of the router it sits in. From these it picks the output port for the next hop on a shortest path.

The dimension order of the path is chosen per packet from an even-parity check bit. The check bit is the XOR of every data bit and every coordinate bit of source and destination. A check bit of 0 sends the packet X first, and a check bit of 1 sends it Y first. A downstream router can therefore recompute the bit and tell from the edge the packet arrived on whether it was corrupted. Nothing extra has to be sent.

When source and destination share a row or a column, only one shortest path exists. In that case the path cannot carry the check, so the bit is appended to the outgoing packet and a flag marks it as present. Results are registered behind a valid/ready handshake.

Top module: `psr_route_encoder`

## Requirements
- R1: After synchronous reset, `out_valid` is 0 and `in_ready` is 1.
- R2: The check bit is the XOR reduction of `in_data`, `in_src_x`, `in_src_y`, `in_dst_x` and `in_dst_y` taken together.
- R3: When the current node equals the destination, `out_port` is Local (5'b10000), and `out_par_present` and `out_par_bit` are both 0.
- R4: When source and destination differ in both coordinates and the check bit is 0, the X coordinate is corrected first: East (5'b00100) if the destination X is larger, West (5'b00001) if smaller. Once X matches, the Y coordinate is corrected.
- R5: When source and destination differ in both coordinates and the check bit is 1, the Y coordinate is corrected first: South (5'b00010) if the destination Y is larger (Y grows downward), North (5'b01000) if smaller. Once Y matches, the X coordinate is corrected.
- R6: When source and destination share X or Y and the current node is not the destination, `out_par_present` is 1 and `out_par_bit` equals the check bit. When they share neither coordinate, both outputs are 0.
- R7: Whenever `out_valid` is 1, `out_port` has exactly one bit set. The bit order is {Local, North, East, South, West}, from bit 4 down to bit 0.
- R8: An input accepted on a clock edge (`in_valid` and `in_ready` both 1) produces its result with `out_valid` 1 right after that edge. Data and addresses are passed through unchanged.
- R9: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0, all outputs hold their values, and a presented input is not taken.
- R10: With `out_ready` held at 1, a new input is accepted on every clock edge. The results appear in order, one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Header offered |
| in_ready | output | 1 | Header can be taken |
| in_data | input | DW | Data word |
| in_src_x | input | CW | Source X |
| in_src_y | input | CW | Source Y |
| in_dst_x | input | CW | Destination X |
| in_dst_y | input | CW | Destination Y |
| cur_x | input | CW | This router's X |
| cur_y | input | CW | This router's Y |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Result consumed |
| out_port | output | 5 | One-hot output port |
| out_par_present | output | 1 | Appended check bit is present |
| out_par_bit | output | 1 | Appended check bit |
| out_data | output | DW | Data word |
| out_src_x | output | CW | Source X |
| out_src_y | output | CW | Source Y |
| out_dst_x | output | CW | Destination X |
| out_dst_y | output | CW | Destination Y |

## Verification
The bench forces each check-bit value by adjusting one data bit. It then confirms that the two values take different first hops for a diagonal pair. A design that ignored the bit, or that swapped the mapping, would route both values the same way or the wrong way round.

Packets whose source and destination share only a row or only a column are sent from mid-path nodes. These catch a flag raised for diagonal pairs, or one missing for aligned pairs. Packets that have arrived at their destination check Local delivery with no appended bit. Other packets turn the corner in both orders, which catches an inverted North/South sense.

A stall with a second header waiting exposes outputs that change under backpressure, or a header that is taken early.

// File: rtl/psr_pkg.sv
package psr_pkg;
  typedef logic [4:0] port_oh_t;
  localparam port_oh_t PORT_LOCAL = 5'b10000;
  localparam port_oh_t PORT_NORTH = 5'b01000;
  localparam port_oh_t PORT_EAST  = 5'b00100;
  localparam port_oh_t PORT_SOUTH = 5'b00010;
  localparam port_oh_t PORT_WEST  = 5'b00001;
  localparam int AXES = 2;
endpackage

// File: rtl/psr_parity.sv
module psr_parity #(
  parameter int DW = 8,
  parameter int CW = 2
) (
  input  logic [DW-1:0] data,
  input  logic [CW-1:0] src_x,
  input  logic [CW-1:0] src_y,
  input  logic [CW-1:0] dst_x,
  input  logic [CW-1:0] dst_y,
  output logic          chk,
  output logic          aligned
);
  localparam int FW = DW + 4 * CW;
  logic [FW-1:0] field;

  always_comb begin
    field   = {data, src_x, src_y, dst_x, dst_y};
    chk     = ^field;
    aligned = (src_x == dst_x) || (src_y == dst_y);
  end
endmodule

// File: rtl/psr_axis_step.sv
module psr_axis_step #(
  parameter int CW = 2
) (
  input  logic [CW-1:0] here,
  input  logic [CW-1:0] there,
  output logic          move,
  output logic          upward
);
  always_comb begin
    move   = (here != there);
    upward = (there > here);
  end
endmodule

// File: rtl/psr_port_sel.sv
module psr_port_sel
  import psr_pkg::*;
#(
  parameter int CW = 2
) (
  input  logic [CW-1:0] cur_x,
  input  logic [CW-1:0] cur_y,
  input  logic [CW-1:0] dst_x,
  input  logic [CW-1:0] dst_y,
  input  logic          y_first,
  output port_oh_t      port
);
  logic [AXES-1:0][CW-1:0] here_v;
  logic [AXES-1:0][CW-1:0] there_v;
  logic [AXES-1:0]         mv;
  logic [AXES-1:0]         up;

  assign here_v  = {cur_y, cur_x};
  assign there_v = {dst_y, dst_x};

  for (genvar g = 0; g < AXES; g++) begin : g_axis
    psr_axis_step #(.CW(CW)) u_step (
      .here  (here_v[g]),
      .there (there_v[g]),
      .move  (mv[g]),
      .upward(up[g])
    );
  end

  always_comb begin
    if (mv == '0)
      port = PORT_LOCAL;
    else if (mv[0] && (!y_first || !mv[1]))
      port = up[0] ? PORT_EAST : PORT_WEST;
    else
      port = up[1] ? PORT_SOUTH : PORT_NORTH;
  end
endmodule

// File: rtl/psr_out_stage.sv
module psr_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_pay,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_pay
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_pay   <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_pay <= in_pay;
    end
  end

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pay)));
  assert_accept_latency_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);
endmodule

// File: rtl/psr_route_encoder.sv
module psr_route_encoder
  import psr_pkg::*;
#(
  parameter int MESH_X = 4,
  parameter int MESH_Y = 4,
  parameter int DW     = 8,
  parameter int CW     = $clog2((MESH_X > MESH_Y) ? MESH_X : MESH_Y)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic [CW-1:0] in_src_x,
  input  logic [CW-1:0] in_src_y,
  input  logic [CW-1:0] in_dst_x,
  input  logic [CW-1:0] in_dst_y,
  input  logic [CW-1:0] cur_x,
  input  logic [CW-1:0] cur_y,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [4:0]    out_port,
  output logic          out_par_present,
  output logic          out_par_bit,
  output logic [DW-1:0] out_data,
  output logic [CW-1:0] out_src_x,
  output logic [CW-1:0] out_src_y,
  output logic [CW-1:0] out_dst_x,
  output logic [CW-1:0] out_dst_y
);
  localparam int PW = 5 + 2 + DW + 4 * CW;

  logic     chk, aligned, at_dst, y_first;
  port_oh_t hop;
  logic [PW-1:0] pay_d, pay_q;

  psr_parity #(.DW(DW), .CW(CW)) u_par (
    .data(in_data), .src_x(in_src_x), .src_y(in_src_y),
    .dst_x(in_dst_x), .dst_y(in_dst_y), .chk(chk), .aligned(aligned)
  );

  assign at_dst  = (cur_x == in_dst_x) && (cur_y == in_dst_y);
  assign y_first = chk && !aligned;

  psr_port_sel #(.CW(CW)) u_sel (
    .cur_x(cur_x), .cur_y(cur_y), .dst_x(in_dst_x), .dst_y(in_dst_y),
    .y_first(y_first), .port(hop)
  );

  assign pay_d = {hop, aligned && !at_dst, chk && aligned && !at_dst,
                  in_data, in_src_x, in_src_y, in_dst_x, in_dst_y};

  psr_out_stage #(.W(PW)) u_out (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_pay(pay_d), .out_valid(out_valid), .out_ready(out_ready), .out_pay(pay_q)
  );

  assign {out_port, out_par_present, out_par_bit,
          out_data, out_src_x, out_src_y, out_dst_x, out_dst_y} = pay_q;

  assert_port_onehot_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($countones(out_port) == 1));
  assert_local_delivery_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && cur_x == in_dst_x && cur_y == in_dst_y)
      |=> (out_port == PORT_LOCAL && !out_par_present && !out_par_bit));
  assert_flag_aligned_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && (in_src_x != in_dst_x) && (in_src_y != in_dst_y))
      |=> (!out_par_present && !out_par_bit));
  assert_y_first_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && (in_src_x != in_dst_x) && (in_src_y != in_dst_y)
     && (cur_y != in_dst_y)
     && ^{in_data, in_src_x, in_src_y, in_dst_x, in_dst_y})
      |=> (out_port == PORT_NORTH || out_port == PORT_SOUTH));
  assert_x_first_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && (in_src_x != in_dst_x) && (in_src_y != in_dst_y)
     && (cur_x != in_dst_x)
     && !(^{in_data, in_src_x, in_src_y, in_dst_x, in_dst_y}))
      |=> (out_port == PORT_EAST || out_port == PORT_WEST));
  assert_ready_stall_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: tb/psr_route_encoder_tb_top.sv
module psr_route_encoder_tb_top;
  localparam logic [4:0] L = 5'b10000, N = 5'b01000, E = 5'b00100,
                         S = 5'b00010, W = 5'b00001;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic in_ready, out_valid, out_par_present, out_par_bit;
  logic [7:0] in_data = '0, out_data;
  logic [1:0] in_src_x = '0, in_src_y = '0, in_dst_x = '0, in_dst_y = '0;
  logic [1:0] cur_x = '0, cur_y = '0;
  logic [1:0] out_src_x, out_src_y, out_dst_x, out_dst_y;
  logic [4:0] out_port;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  psr_route_encoder dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_src_x(in_src_x), .in_src_y(in_src_y),
    .in_dst_x(in_dst_x), .in_dst_y(in_dst_y), .cur_x(cur_x), .cur_y(cur_y),
    .out_valid(out_valid), .out_ready(out_ready), .out_port(out_port),
    .out_par_present(out_par_present), .out_par_bit(out_par_bit),
    .out_data(out_data), .out_src_x(out_src_x), .out_src_y(out_src_y),
    .out_dst_x(out_dst_x), .out_dst_y(out_dst_y)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R2: choose data whose XOR with the addresses gives the wanted check bit
  function automatic logic [7:0] force_chk(input logic [7:0] base, input logic [1:0] sx,
      input logic [1:0] sy, input logic [1:0] dx, input logic [1:0] dy, input logic want);
    logic p = ^{base, sx, sy, dx, dy};
    return {base[7:1], base[0] ^ p ^ want};
  endfunction

  function automatic logic [4:0] exp_port(input logic [1:0] sx, input logic [1:0] sy,
      input logic [1:0] dx, input logic [1:0] dy, input logic [1:0] cx,
      input logic [1:0] cy, input logic p);
    logic yf = p && (sx != dx) && (sy != dy);
    if (cx == dx && cy == dy) return L;
    if ((!yf && cx != dx) || (yf && cy == dy)) return (dx > cx) ? E : W;
    return (dy > cy) ? S : N;
  endfunction

  task automatic drive(input logic [7:0] d, input logic [1:0] sx, input logic [1:0] sy,
      input logic [1:0] dx, input logic [1:0] dy, input logic [1:0] cx, input logic [1:0] cy);
    in_valid = 1'b1; in_data = d; in_src_x = sx; in_src_y = sy;
    in_dst_x = dx; in_dst_y = dy; cur_x = cx; cur_y = cy;
  endtask

  task automatic expect_out(input string req, input logic [7:0] d, input logic [1:0] sx,
      input logic [1:0] sy, input logic [1:0] dx, input logic [1:0] dy,
      input logic [1:0] cx, input logic [1:0] cy);
    logic p = ^{d, sx, sy, dx, dy};
    logic atd = (cx == dx) && (cy == dy);
    logic pres = ((sx == dx) || (sy == dy)) && !atd;
    check({req, " valid"}, {31'd0, out_valid}, 32'd1);
    check({req, " port"}, {27'd0, out_port}, {27'd0, exp_port(sx, sy, dx, dy, cx, cy, p)});
    check({req, " flag/bit"}, {30'd0, out_par_present, out_par_bit}, {30'd0, pres, pres & p});
    check({req, " payload R8"}, {16'd0, out_data, out_src_x, out_src_y, out_dst_x, out_dst_y},
          {16'd0, d, sx, sy, dx, dy});
  endtask

  task automatic one(input string req, input logic [7:0] d, input logic [1:0] sx,
      input logic [1:0] sy, input logic [1:0] dx, input logic [1:0] dy,
      input logic [1:0] cx, input logic [1:0] cy);
    @(negedge clk); drive(d, sx, sy, dx, dy, cx, cy);
    @(negedge clk); in_valid = 1'b0;
    expect_out(req, d, sx, sy, dx, dy, cx, cy);
  endtask

  task automatic test_reset();
    check("R1 out_valid", {31'd0, out_valid}, 32'd0);
    check("R1 in_ready", {31'd0, in_ready}, 32'd1);
  endtask

  task automatic test_local();
    one("R3 local aligned", 8'h3C, 2'd0, 2'd1, 2'd3, 2'd1, 2'd3, 2'd1);
    one("R3 local diagonal", 8'hA5, 2'd0, 2'd0, 2'd2, 2'd3, 2'd2, 2'd3);
    check("R3 port", {27'd0, out_port}, {27'd0, L});
  endtask

  task automatic test_x_first();
    logic [7:0] d = force_chk(8'h50, 2'd0, 2'd0, 2'd3, 2'd2, 1'b0);
    one("R4 east first", d, 2'd0, 2'd0, 2'd3, 2'd2, 2'd0, 2'd0);
    check("R4 east", {27'd0, out_port}, {27'd0, E});
    d = force_chk(8'h11, 2'd3, 2'd3, 2'd0, 2'd1, 1'b0);
    one("R4 west first", d, 2'd3, 2'd3, 2'd0, 2'd1, 2'd2, 2'd3);
    check("R4 west", {27'd0, out_port}, {27'd0, W});
    one("R4 turn north", d, 2'd3, 2'd3, 2'd0, 2'd1, 2'd0, 2'd3);
    check("R4 north", {27'd0, out_port}, {27'd0, N});
  endtask

  task automatic test_y_first();
    logic [7:0] d = force_chk(8'h50, 2'd0, 2'd0, 2'd3, 2'd2, 1'b1);
    one("R5 south first", d, 2'd0, 2'd0, 2'd3, 2'd2, 2'd0, 2'd0);
    check("R5 south", {27'd0, out_port}, {27'd0, S});
    one("R5 turn east", d, 2'd0, 2'd0, 2'd3, 2'd2, 2'd0, 2'd2);
    check("R5 east", {27'd0, out_port}, {27'd0, E});
    d = force_chk(8'h77, 2'd2, 2'd3, 2'd0, 2'd0, 1'b1);
    one("R5 north first", d, 2'd2, 2'd3, 2'd0, 2'd0, 2'd2, 2'd3);
    check("R5 north", {27'd0, out_port}, {27'd0, N});
  endtask

  task automatic test_aligned();
    logic [7:0] d = force_chk(8'h0F, 2'd1, 2'd0, 2'd1, 2'd3, 1'b1);
    one("R6 column p1", d, 2'd1, 2'd0, 2'd1, 2'd3, 2'd1, 2'd1);
    check("R6 flag p1", {30'd0, out_par_present, out_par_bit}, 32'd3);
    d = force_chk(8'hF0, 2'd3, 2'd2, 2'd0, 2'd2, 1'b0);
    one("R6 row p0", d, 2'd3, 2'd2, 2'd0, 2'd2, 2'd2, 2'd2);
    check("R6 flag p0", {30'd0, out_par_present, out_par_bit}, 32'd2);
    check("R7 onehot", {31'd0, $countones(out_port) == 1}, 32'd1);
  endtask

  task automatic test_stall();
    logic [7:0] da = force_chk(8'h21, 2'd0, 2'd0, 2'd2, 2'd2, 1'b0);
    logic [7:0] db = force_chk(8'h42, 2'd0, 2'd0, 2'd2, 2'd2, 1'b1);
    @(negedge clk); out_ready = 1'b0; drive(da, 2'd0, 2'd0, 2'd2, 2'd2, 2'd0, 2'd0);
    @(negedge clk); drive(db, 2'd0, 2'd0, 2'd2, 2'd2, 2'd0, 2'd0);
    check("R9 ready low", {31'd0, in_ready}, 32'd0);
    @(negedge clk);
    check("R9 still held", {31'd0, in_ready}, 32'd0);
    expect_out("R9 hold A", da, 2'd0, 2'd0, 2'd2, 2'd2, 2'd0, 2'd0);
    out_ready = 1'b1;
    @(negedge clk); in_valid = 1'b0;
    expect_out("R9 then B", db, 2'd0, 2'd0, 2'd2, 2'd2, 2'd0, 2'd0);
  endtask

  task automatic test_stream();
    logic [7:0] ds [4] = '{8'h01, 8'h82, 8'hC3, 8'h64};
    @(negedge clk); drive(ds[0], 2'd1, 2'd1, 2'd3, 2'd3, 2'd1, 2'd1);
    for (int i = 1; i < 4; i++) begin
      @(negedge clk);
      check("R10 in_ready", {31'd0, in_ready}, 32'd1);
      expect_out("R10 stream", ds[i-1], 2'd1, 2'd1, 2'd3, 2'd3, 2'd1, 2'd1);
      drive(ds[i], 2'd1, 2'd1, 2'd3, 2'd3, 2'd1, 2'd1);
    end
    @(negedge clk); in_valid = 1'b0;
    expect_out("R10 stream last", ds[3], 2'd1, 2'd1, 2'd3, 2'd3, 2'd1, 2'd1);
    @(negedge clk);
    check("R8 idle", {31'd0, out_valid}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    test_reset();
    test_local();
    test_x_first();
    test_y_first();
    test_aligned();
    test_stall();
    test_stream();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule